// File: doc/BRIEF.md
# Fractional microsecond timebase generator

This block derives a one-microsecond time step from a faster reference clock whose frequency need not be a whole number of megahertz. A rational ratio, held in a 16-bit configuration register, says how many ticks to produce for each group of reference clocks. An accumulator spreads those ticks across the group so that the long-run average comes out exact. Examples are one tick per 12 clocks for a 12 MHz reference, and 5 ticks per 64 clocks for a 12.8 MHz reference.

Each tick is a single-clock enable pulse on `tick_o`. The same pulse advances a free-running 32-bit up-counter of microseconds. Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge. Reads return data combinationally from the address. A freeze bit stops the counter without disturbing the phase of the fractional accumulator. After a low-power period, software restores the ratio by writing it again, and that write restarts the accumulator from a clean phase.

Top module: `ustb_timebase`

## Requirements
- R1: After reset, `count_o` is 0, `tick_o` is 0, the configuration reads 0x000b and the freeze bit reads 0.
- R2: The configuration register sits at address 0x14. Bits [7:0] hold (clocks per period − 1) and bits [15:8] hold (ticks per period − 1). Reads return those 16 bits zero-extended, and write data above bit 15 is dropped.
- R3: When a configuration has ticks ≤ clocks, `tick_o` is high in exactly (ticks) of every (clocks) consecutive cycles after a configuration write. For example, 0x000b gives 1 in 12, 0x043f gives 5 in 64 and 0x04bf gives 5 in 192.
- R4: `tick_o` is a one-cycle pulse. Under 0x000b it is never high in two consecutive cycles. When the ticks field is greater than or equal to the clocks field, `tick_o` is high in every cycle.
- R5: A configuration write, including one that repeats the current value, clears the accumulator phase. It also holds `tick_o` low in the cycle that follows the write.
- R6: The counter, readable at address 0x10 and on `count_o`, advances by exactly one on the edge after each cycle in which `tick_o` is high and freeze is clear. Writes to address 0x10 have no effect on it.
- R7: The freeze bit is bit 0 at address 0x4c and reads back as written. While it is set, the counter holds its value, while `tick_o` and the accumulator phase continue unchanged.
- R8: A read of any address other than 0x10, 0x14 or 0x4c returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_o | output | 1 | One-cycle microsecond tick enable |
| count_o | output | 32 | Free-running microsecond count |

## Verification
A wrong accumulator phase or step size shows up as a wrong tick count within one ratio period after a configuration write. The bench counts ticks over whole periods, so that error surfaces at most a few hundred clocks later. A counter that misses or double-counts a tick gives a counter delta that differs from the observed tick count by the end of the same window. A freeze that leaks into the accumulator moves the tick total of a window that spans the freeze, which makes it visible once that window ends.

// File: rtl/ustb_pkg.sv
package ustb_pkg;
    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_RATIO  = 8'h14;
    localparam logic [7:0] OFS_FREEZE = 8'h4c;

    // Width of one ratio field (clocks-per-period or ticks-per-period, n+1 coded).
    localparam int unsigned RATIO_FIELD_W = 8;
endpackage

// File: rtl/ustb_ratio_acc.sv
module ustb_ratio_acc #(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic [FIELD_W-1:0] clk_field_i,
    input  logic [FIELD_W-1:0] tick_field_i,
    output logic               tick_o
);
    localparam int unsigned SUM_W = FIELD_W + 2;

    typedef struct packed {
        logic [SUM_W-1:0] phase;
        logic             tick;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [SUM_W-1:0] modulus, step, sum;

    always_comb begin
        modulus = SUM_W'(clk_field_i) + SUM_W'(1);
        step    = SUM_W'(tick_field_i) + SUM_W'(1);
        sum     = st_q.phase + step;
        st_d    = st_q;
        if (restart_i) begin
            st_d.phase = '0;
            st_d.tick  = 1'b0;
        end else if (step >= modulus) begin
            st_d.phase = '0;
            st_d.tick  = 1'b1;
        end else if (sum >= modulus) begin
            st_d.phase = sum - modulus;
            st_d.tick  = 1'b1;
        end else begin
            st_d.phase = sum;
            st_d.tick  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < modulus);
    p_restart_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!tick_o && st_q.phase == '0));
    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && tick_field_i >= clk_field_i) |=> tick_o);
endmodule

// File: rtl/ustb_counter.sv
module ustb_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i && !hold_i) begin
            st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.value;

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(count_o));
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !hold_i) |=> (count_o == $past(count_o) + CNT_W'(1)));
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o));
endmodule

// File: rtl/ustb_regfile.sv
module ustb_regfile
    import ustb_pkg::*;
#(
    parameter int unsigned          FIELD_W   = RATIO_FIELD_W,
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 32,
    parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000b
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [2*FIELD_W-1:0] ratio_o,
    output logic                 freeze_o,
    output logic                 ratio_wr_o
);
    localparam int unsigned RATIO_W = 2 * FIELD_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               freeze;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit_ratio, hit_freeze;

    always_comb begin
        hit_ratio  = wr_en && (addr == ADDR_W'(OFS_RATIO));
        hit_freeze = wr_en && (addr == ADDR_W'(OFS_FREEZE));
        st_d       = st_q;
        if (hit_ratio) begin
            st_d.ratio = wdata[RATIO_W-1:0];
        end
        if (hit_freeze) begin
            st_d.freeze = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ratio  <= RATIO_RST;
            st_q.freeze <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o    = st_q.ratio;
    assign freeze_o   = st_q.freeze;
    assign ratio_wr_o = hit_ratio;

    p_ratio_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_RATIO)) |=> (ratio_o == $past(wdata[RATIO_W-1:0])));
    p_freeze_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_FREEZE)) |=> (freeze_o == $past(wdata[0])));
endmodule

// File: rtl/ustb_timebase.sv
module ustb_timebase
    import ustb_pkg::*;
#(
    parameter int unsigned          FIELD_W   = RATIO_FIELD_W,
    parameter int unsigned          CNT_W     = 32,
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 32,
    parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tick_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int unsigned RATIO_W = 2 * FIELD_W;

    logic [RATIO_W-1:0] ratio;
    logic               freeze;
    logic               ratio_wr;
    logic               tick;
    logic [CNT_W-1:0]   count;

    ustb_regfile #(
        .FIELD_W  (FIELD_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RATIO_RST(RATIO_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .ratio_o   (ratio),
        .freeze_o  (freeze),
        .ratio_wr_o(ratio_wr)
    );

    ustb_ratio_acc #(
        .FIELD_W(FIELD_W)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (ratio_wr),
        .clk_field_i (ratio[FIELD_W-1:0]),
        .tick_field_i(ratio[RATIO_W-1:FIELD_W]),
        .tick_o      (tick)
    );

    ustb_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .hold_i (freeze),
        .count_o(count)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_COUNT)) begin
            rdata = DATA_W'(count);
        end else if (addr == ADDR_W'(OFS_RATIO)) begin
            rdata = DATA_W'(ratio);
        end else if (addr == ADDR_W'(OFS_FREEZE)) begin
            rdata = DATA_W'(freeze);
        end
    end

    assign tick_o  = tick;
    assign count_o = count;

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != ADDR_W'(OFS_COUNT) && addr != ADDR_W'(OFS_RATIO) &&
         addr != ADDR_W'(OFS_FREEZE)) |-> (rdata == '0));
    p_count_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_COUNT)) |-> (rdata == DATA_W'(count_o)));
endmodule

// File: tb/ustb_timebase_bench.sv
module ustb_timebase_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_o;
    logic [31:0] count_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ustb_timebase u_ustb_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .tick_o (tick_o),
        .count_o(count_o)
    );

    function automatic int exp_window_ticks(logic [15:0] r, int periods);
        int c = int'(r[7:0]) + 1;
        int t = int'(r[15:8]) + 1;
        if (t >= c) return periods * c;
        return periods * t;
    endfunction

    function automatic logic [31:0] exp_ratio_read(logic [31:0] w);
        return {16'h0, w[15:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 8'h00;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        addr = a; #1;
        d = rdata;
        addr = 8'h00;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Write a ratio, count ticks over whole periods, compare counter delta.
    task automatic ratio_window(string req, logic [31:0] w, int periods);
        int ticks = 0, pairs = 0, n;
        logic prev = 1'b0;
        logic [31:0] c0, c1;
        bus_write(8'h14, w);
        check("R5", {31'h0, tick_o}, 32'h0);
        c0 = count_o;
        n  = (int'(w[7:0]) + 1) * periods;
        for (int i = 0; i < n; i++) begin
            step();
            if (tick_o) ticks++;
            if (tick_o && prev) pairs++;
            prev = tick_o;
        end
        step();
        c1 = count_o;
        check(req, ticks, exp_window_ticks(w[15:0], periods));
        check("R6", c1 - c0, ticks);
        if (w[15:0] == 16'h000b) check("R4", pairs, 0);
    endtask

    initial begin
        logic [31:0] rd, c0;
        int ticks;
        void'($urandom(32'h5eed_1234));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1", count_o, 32'h0);
        check("R1", {31'h0, tick_o}, 32'h0);
        bus_read(8'h14, rd); check("R1", rd, 32'h0000_000b);
        bus_read(8'h4c, rd); check("R1", rd, 32'h0);
        // R8 unmapped reads
        bus_read(8'h00, rd); check("R8", rd, 32'h0);
        bus_read(8'h18, rd); check("R8", rd, 32'h0);
        // R2 field layout and upper data dropped
        bus_write(8'h14, 32'hdead_043f);
        bus_read(8'h14, rd); check("R2", rd, exp_ratio_read(32'hdead_043f));
        // R3 directed ratios
        ratio_window("R3", 32'h0000_000b, 3);
        ratio_window("R3", 32'h0000_043f, 2);
        ratio_window("R3", 32'h0000_04bf, 2);
        ratio_window("R3", 32'h0000_0453, 1);
        // R4 saturation: ticks field >= clocks field
        ratio_window("R4", 32'h0000_0503, 4);
        ratio_window("R4", 32'h0000_0707, 2);
        // R5 rewrite of same value restarts phase
        bus_write(8'h14, 32'h0000_000b);
        repeat (5) step();
        ratio_window("R5", 32'h0000_000b, 2);
        // R6 write to counter ignored
        c0 = count_o;
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, rd);
        check("R6", (rd == c0 || rd == c0 + 1) ? 32'h1 : 32'h0, 32'h1);
        // R7 freeze: counter holds, ticks continue, phase kept
        bus_write(8'h14, 32'h0000_043f);
        ticks = 0;
        for (int i = 0; i < 10; i++) begin step(); if (tick_o) ticks++; end
        bus_write(8'h4c, 32'h1);
        if (tick_o) ticks++;
        bus_read(8'h4c, rd); check("R7", rd, 32'h1);
        step(); if (tick_o) ticks++;
        c0 = count_o;
        for (int i = 0; i < 40; i++) begin step(); if (tick_o) ticks++; end
        check("R7", count_o, c0);
        bus_write(8'h4c, 32'h0);
        if (tick_o) ticks++;
        for (int i = 0; i < 64 - 53; i++) begin step(); if (tick_o) ticks++; end
        check("R7", ticks, 5);
        // Random ratios
        for (int k = 0; k < 40; k++) begin
            logic [7:0] cf, tf;
            cf = 8'($urandom_range(0, 255));
            tf = 8'($urandom_range(0, int'(cf)));
            ratio_window("R3", {16'h0, tf, cf}, int'($urandom_range(1, 2)));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule